// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the faster module clock. A 13-bit clock control word selects one of two division laws. The linear law gives an even ratio of twice an 8-bit count plus one. The power-of-two law divides by two raised to a 4-bit exponent.

During a transfer the block counts module-clock cycles, toggles an internal phase at every half-period boundary and emits two one-cycle strobes. One strobe marks each edge that leaves the idle level, and the other marks each edge that returns to it. A data shifter uses the strobes with its clock-phase setting to choose its launch and capture edges.

Outside a transfer the serial clock rests at the level set by the polarity input. The control word and the polarity are captured only when a transfer begins.

Top module: `spi_sck_divider`

## Requirements
- R1: While `xfer_active_i` is low, `sck_o` equals `cpol_i` (1 = idle high) and both strobes are low.
- R2: With bit 12 of `clk_cfg_i` set (linear law), each half-period lasts N2+1 module cycles, where N2 = `clk_cfg_i[7:0]`. The full period is therefore 2×(N2+1).
- R3: With bit 12 clear (power-of-two law) and N1 = `clk_cfg_i[11:8]` at least 1, the full period is 2^N1 module cycles and each half-period is 2^(N1-1).
- R4: In the power-of-two law with N1 = 0, the block divides by 2, giving one cycle high and one cycle low.
- R5: Let the start edge be the first rising clock edge at which `xfer_active_i` is high after a cycle where it was low. With H the half-period, `sck_o` shows the captured idle level through start edge +H-1. It first changes after start edge +H and then toggles every H edges.
- R6: `clk_cfg_i` and `cpol_i` are sampled at the start edge. Changing either during a transfer has no effect on `sck_o` or on the strobes until the next transfer.
- R7: When `xfer_active_i` falls, `sck_o` returns to the idle level after the next edge. The following transfer restarts its half-period count from zero.
- R8: `lead_tick_o` is high for exactly the cycle in which `sck_o` leaves the idle level, and `trail_tick_o` for exactly the cycle in which it returns. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_cfg_i | input | 13 | Clock control word: linear count [7:0], exponent [11:8], law select [12] |
| cpol_i | input | 1 | Idle level of the serial clock |
| xfer_active_i | input | 1 | High for the duration of a transfer |
| sck_o | output | 1 | Serial clock |
| lead_tick_o | output | 1 | One-cycle strobe on each edge away from idle |
| trail_tick_o | output | 1 | One-cycle strobe on each edge back to idle |

## Verification
The bench checks the exponent-zero case. A design that applied the power-of-two law literally there would either stall or run at the module clock rate, and the divide-by-2 waveform comparison catches both.

It uses the largest exponent, where a counter that is too narrow wraps early and shortens the half-period. It also uses the linear count 0 and 255, which expose off-by-one errors in the N2+1 law.

Mid-transfer writes to the control word and the polarity input expose any design that samples them live. Such a design would produce a period change or an inverted clock partway through a transfer. Transfers that stop partway through a half-period check that the count restarts from zero and does not carry stale state into the next transfer.

// File: rtl/spi_sck_div_pkg.sv
package spi_sck_div_pkg;
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_law_e;
endpackage

// File: rtl/spi_sck_cfg_latch.sv
module spi_sck_cfg_latch
  import spi_sck_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 14,
  localparam int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             cpol_i,
  output logic [CNT_W-1:0] half_m1_o,
  output logic             cpol_o
);
  localparam int MODE_BIT = LIN_W + EXP_W;

  div_law_e         law;
  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_n;
  logic [EXP_W-1:0] exp_m1;
  logic [CNT_W-1:0] half_m1_d;

  assign law    = div_law_e'(cfg_i[MODE_BIT]);
  assign lin_n  = cfg_i[LIN_W-1:0];
  assign exp_n  = cfg_i[MODE_BIT-1:LIN_W];
  assign exp_m1 = exp_n - EXP_W'(1);

  // half-period minus one; exponent 0 folds onto divide-by-2
  always_comb begin
    if (law == DIV_LINEAR) begin
      half_m1_d = CNT_W'(lin_n);
    end else if (exp_n == '0) begin
      half_m1_d = '0;
    end else begin
      half_m1_d = (CNT_W'(1) << exp_m1) - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_m1_o <= '0;
      cpol_o    <= 1'b0;
    end else if (load_i) begin
      half_m1_o <= half_m1_d;
      cpol_o    <= cpol_i;
    end
  end
endmodule

// File: rtl/spi_sck_phase_gen.sv
module spi_sck_phase_gen #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_m1_i,
  output logic             phase_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (cnt_q == half_m1_i) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
      lead_o  <= ~phase_o;
      trail_o <= phase_o;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sck_out.sv
module spi_sck_out (
  input  logic running_i,
  input  logic phase_i,
  input  logic cpol_lat_i,
  input  logic cpol_i,
  output logic sck_o
);
  assign sck_o = running_i ? (phase_i ^ cpol_lat_i) : cpol_i;
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] clk_cfg_i,
  input  logic             cpol_i,
  input  logic             xfer_active_i,
  output logic             sck_o,
  output logic             lead_tick_o,
  output logic             trail_tick_o
);
  localparam int POW_W = (2 ** EXP_W) - 2;
  localparam int CNT_W = (LIN_W > POW_W) ? LIN_W : POW_W;

  logic             running_q;
  logic             load;
  logic             run;
  logic [CNT_W-1:0] half_m1;
  logic             cpol_lat;
  logic             phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) running_q <= 1'b0;
    else         running_q <= xfer_active_i;
  end

  assign load = xfer_active_i & ~running_q;
  assign run  = xfer_active_i & running_q;

  spi_sck_cfg_latch #(
    .LIN_W(LIN_W),
    .EXP_W(EXP_W),
    .CNT_W(CNT_W)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .cfg_i    (clk_cfg_i),
    .cpol_i   (cpol_i),
    .half_m1_o(half_m1),
    .cpol_o   (cpol_lat)
  );

  spi_sck_phase_gen #(
    .CNT_W(CNT_W)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .half_m1_i(half_m1),
    .phase_o  (phase),
    .lead_o   (lead_tick_o),
    .trail_o  (trail_tick_o)
  );

  spi_sck_out u_out (
    .running_i (running_q),
    .phase_i   (phase),
    .cpol_lat_i(cpol_lat),
    .cpol_i    (cpol_i),
    .sck_o     (sck_o)
  );
endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic xfer_active_i,
  input logic cpol_i,
  input logic sck_o,
  input logic lead_tick_o,
  input logic trail_tick_o
);
  a_r1_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_active_i |=> (sck_o == cpol_i));

  a_r1_ticks_need_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_tick_o || trail_tick_o) |-> $past(xfer_active_i));

  a_r8_tick_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_tick_o && trail_tick_o));

  a_r8_no_back_to_back_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_tick_o |=> !lead_tick_o);

  a_r8_lead_moves_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_tick_o |-> (sck_o != $past(sck_o)));

  a_r8_trail_moves_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_tick_o |-> (sck_o != $past(sck_o)));

  a_r5_edge_has_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(xfer_active_i) && $past(xfer_active_i, 2) && (sck_o != $past(sck_o)))
      |-> (lead_tick_o || trail_tick_o));
endmodule

bind spi_sck_divider spi_sck_divider_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xfer_active_i(xfer_active_i),
  .cpol_i       (cpol_i),
  .sck_o        (sck_o),
  .lead_tick_o  (lead_tick_o),
  .trail_tick_o (trail_tick_o)
);

// File: tb/spi_sck_divider_bench.sv
module spi_sck_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] clk_cfg_i = '0;
  logic        cpol_i = 1'b0;
  logic        xfer_active_i = 1'b0;
  logic        sck_o, lead_tick_o, trail_tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_sck_divider u_spi_sck_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_cfg_i(clk_cfg_i), .cpol_i(cpol_i),
    .xfer_active_i(xfer_active_i), .sck_o(sck_o),
    .lead_tick_o(lead_tick_o), .trail_tick_o(trail_tick_o)
  );

  // half-period from the division law
  function automatic int half_len(logic [12:0] cfg);
    if (cfg[12]) return int'(cfg[7:0]) + 1;
    if (cfg[11:8] == 4'd0) return 1;
    return 1 << (int'(cfg[11:8]) - 1);
  endfunction

  task automatic check3(string req, logic s, logic l, logic t,
                        logic es, logic el, logic et);
    checks++;
    if (s !== es || l !== el || t !== et) begin
      failures++;
      $display("FAIL %s: sck/lead/trail actual=%b%b%b expected=%b%b%b at %0t",
               req, s, l, t, es, el, et, $time);
    end
  endtask

  // runs ncyc edges of a transfer; optionally rewrites inputs halfway
  task automatic run_xfer(logic [12:0] cfg, logic cpol, int ncyc, bit disturb);
    int  h;
    string req;
    h = half_len(cfg);
    req = cfg[12] ? "R2" : ((cfg[11:8] == 4'd0) ? "R4" : "R3");
    @(negedge clk_i);
    clk_cfg_i = cfg;
    cpol_i = cpol;
    xfer_active_i = 1'b1;
    for (int j = 0; j < ncyc; j++) begin
      int  tg;
      bit  at_b;
      logic es;
      string r;
      @(negedge clk_i);
      tg   = j / h;
      at_b = (j > 0) && (j % h == 0);
      es   = cpol ^ logic'(tg & 1);
      r    = (j <= h) ? "R5" : ((disturb && j > ncyc / 2) ? "R6" : req);
      check3(r, sck_o, lead_tick_o, trail_tick_o,
             es, at_b && (tg % 2 == 1), at_b && (tg % 2 == 0));
      if (at_b) check3("R8", sck_o, lead_tick_o, trail_tick_o,
                       es, (tg % 2 == 1), (tg % 2 == 0));
      if (disturb && j == ncyc / 2) begin
        clk_cfg_i = ~cfg;
        cpol_i    = ~cpol;
      end
    end
    xfer_active_i = 1'b0;
    @(negedge clk_i);
    check3("R7", sck_o, lead_tick_o, trail_tick_o, cpol_i, 1'b0, 1'b0);
    cpol_i = ~cpol_i;
    #1;
    check3("R1", sck_o, lead_tick_o, trail_tick_o, cpol_i, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    // R1 reset state
    check3("R1", sck_o, lead_tick_o, trail_tick_o, 1'b0, 1'b0, 1'b0);
    cpol_i = 1'b1;
    #1;
    check3("R1", sck_o, lead_tick_o, trail_tick_o, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check3("R1", sck_o, lead_tick_o, trail_tick_o, 1'b1, 1'b0, 1'b0);

    // R4 exponent 0 -> divide by 2
    run_xfer({1'b0, 4'd0, 8'hA5}, 1'b0, 12, 1'b0);
    run_xfer({1'b0, 4'd0, 8'h00}, 1'b1, 9, 1'b0);
    // R2 linear extremes
    run_xfer({1'b1, 4'hF, 8'd0}, 1'b0, 10, 1'b0);
    run_xfer({1'b1, 4'h0, 8'd255}, 1'b1, 1100, 1'b0);
    // R3 small and largest exponent
    run_xfer({1'b0, 4'd1, 8'hFF}, 1'b0, 8, 1'b0);
    run_xfer({1'b0, 4'd15, 8'h00}, 1'b1, 2 * 16384 + 3, 1'b0);
    // R6 mid-transfer disturbance
    run_xfer({1'b1, 4'd3, 8'd4}, 1'b0, 60, 1'b1);
    run_xfer({1'b0, 4'd4, 8'd9}, 1'b1, 70, 1'b1);
    // R7 stop mid half-period, then restart
    run_xfer({1'b1, 4'd0, 8'd9}, 1'b0, 15, 1'b0);
    run_xfer({1'b1, 4'd0, 8'd9}, 1'b0, 45, 1'b0);

    for (int k = 0; k < 24; k++) begin
      logic [12:0] cfg;
      int h;
      cfg = 13'($urandom);
      if (!cfg[12]) cfg[11:8] = 4'($urandom % 10);
      h = half_len(cfg);
      run_xfer(cfg, 1'($urandom), 4 * h + int'($urandom % h) + 1, 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule